// File: doc/BRIEF.md
# Interrupt Coalescing Controller

This block sits between a network controller's transmit and receive ring engines and the register that records interrupt causes. Its purpose is to raise fewer interrupts. It gathers cause bits into an accumulator and keeps separate counts of pending transmit and receive work. An interrupt is raised at once only in a few cases:

- the first receive event of a window;
- the first receive event that reports a low-buffer condition;
- a transmit ring that is close to full.

Every other event is deferred. A deferred event is delivered when an external flush strobe arrives, which an idle detector or a timer drives.

Interrupt requests leave the block as a one-cycle set pulse that carries the merged cause vector. A flush that delivers also raises a kick, which asks the transmit engine to run again. When several events arrive in the same cycle, they are handled in a fixed order: transmit first, then receive, then flush. All deliveries in that cycle merge into one pulse.

Top module: `irq_coalescer`

## Requirements
- R1: After a synchronous active-low reset, `irq_set` and `tx_kick` are low. The transmit count, the receive count, the accumulator and the armed flag are all zero.
- R2: Transmit pending work is `tx_tail - tx_head`. When `tx_tail < tx_head`, `ring_len` is added to that difference.
- R3: A transmit request is dropped when the transmit count is above 4 and the count plus pending is below `ring_len - 5`. A dropped request adds neither cause bits nor count.
- R4: An accepted transmit request adds its pending work to the transmit count and ORs `tx_cause` into the accumulator. If the new count is at least `ring_len - 5`, the block delivers the accumulator and clears the count and the accumulator; otherwise it arms a deferred flush.
- R5: A receive event that sees a receive count of zero delivers the accumulator, including the event's own bits, and sets the receive count to 1.
- R6: A receive event with `rx_low` high and a receive count below `RX_SENTINEL` delivers at once and sets the count to `RX_SENTINEL`. A second such event in the same window therefore does not deliver.
- R7: Every other receive event ORs in its cause bits, increments the receive count and arms a deferred flush.
- R8: A flush that arrives while the block is armed, with either count non-zero, does four things: it clears both counts, pulses `tx_kick`, delivers the accumulator and clears it.
- R9: A flush while the block is not armed does nothing. A flush while both counts are zero clears the armed flag and does nothing else. Neither case pulses `irq_set` or `tx_kick`. An immediate delivery that leaves both counts at zero clears the armed flag.
- R10: Events in the same cycle are applied in the order transmit, receive, flush. All deliveries in that cycle merge into one pulse whose vector is the OR of the delivered causes. New bits are never lost.
- R11: Both counts saturate at their all-ones value and never wrap.
- R12: The outputs are registered. They reflect the inputs sampled at a clock edge, they are visible after that edge, and they return low in the next cycle that does not deliver.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_req | input | 1 | Transmit work request strobe |
| tx_head | input | IDX_W | Transmit ring head index |
| tx_tail | input | IDX_W | Transmit ring tail index |
| ring_len | input | IDX_W | Transmit ring length in descriptors |
| tx_cause | input | CAUSE_W | Cause bits of the transmit request |
| rx_evt | input | 1 | Receive event strobe |
| rx_cause | input | CAUSE_W | Cause bits of the receive event |
| rx_low | input | 1 | Receive buffers below low threshold |
| flush | input | 1 | Idle or timer flush strobe |
| irq_set | output | 1 | One-cycle interrupt-set pulse |
| irq_cause | output | CAUSE_W | Cause vector delivered with `irq_set` |
| tx_kick | output | 1 | Request to rerun the transmit engine |

## Verification
The bench targets the following corner cases:

- **Ring wrap.** A head index above the tail must wrap through the ring length. A design that got this wrong would compute a huge pending value and fire on the first request.
- **Drop window.** A design that still accumulated the cause bits of a dropped request would leak those bits into the next delivered vector.
- **One-shot low-threshold bypass.** A design that let the bypass fire twice would interrupt again inside the same window.
- **Saturation.** A receive count that wrapped to zero would make the next event look like a first event and fire at once.
- **Same-cycle merge.** A transmit event and a first receive event in one cycle must produce a single merged vector.
- **Stale flushes.** A flush after an immediate delivery has emptied the counts must stay silent.

// File: rtl/irq_coal_pkg.sv
// Package: constants shared by the interrupt coalescing controller.
// Assumes: nothing; it holds only fixed policy numbers.
package irq_coal_pkg;
    // Transmit requests always accepted while the count is at or below this value.
    localparam int TX_FIRST_EVENTS = 4;
    // Distance from ring length at which the transmit ring counts as nearly full.
    localparam int TX_HEADROOM     = 5;
endpackage

// File: rtl/irq_coal_sat_add.sv
// Module: saturating unsigned adder.
// Adds b to a and clamps the result to all-ones instead of wrapping.
// Assumes: BW <= W.
module irq_coal_sat_add #(
    parameter int W  = 17,
    parameter int BW = 1
) (
    input  logic [W-1:0]  a,
    input  logic [BW-1:0] b,
    output logic [W-1:0]  y
);
    logic [W:0] sum;

    // Widen by one bit so the carry out marks an overflow.
    assign sum = {1'b0, a} + {{(W + 1 - BW){1'b0}}, b};
    // Clamp on overflow.
    assign y   = sum[W] ? {W{1'b1}} : sum[W-1:0];
endmodule

// File: rtl/irq_coal_tx_gate.sv
// Module: transmit-side decision logic.
// Computes ring occupancy from head and tail, decides whether a request is
// dropped, forms the saturated new count and flags a nearly full ring.
// Assumes: head and tail are both below len; IDX_W + 1 <= CNT_W.
module irq_coal_tx_gate
    import irq_coal_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int CNT_W = 17
) (
    input  logic [IDX_W-1:0] head,
    input  logic [IDX_W-1:0] tail,
    input  logic [IDX_W-1:0] len,
    input  logic [CNT_W-1:0] cnt,
    output logic             drop,
    output logic             full,
    output logic [CNT_W-1:0] cnt_sum
);
    localparam int WW = CNT_W + 2;

    logic [IDX_W:0] pend;

    // Pending descriptors; wrap through the ring length when the tail is behind the head.
    always_comb begin
        pend = {1'b0, tail} - {1'b0, head};
        if (tail < head)
            pend = pend + {1'b0, len};
    end

    // Drop once past the first few requests while the ring is far from full.
    assign drop = (cnt > CNT_W'(TX_FIRST_EVENTS)) &&
                  ((WW'(cnt) + WW'(pend) + WW'(TX_HEADROOM)) < WW'(len));

    irq_coal_sat_add #(.W(CNT_W), .BW(IDX_W + 1)) u_sum (
        .a (cnt),
        .b (pend),
        .y (cnt_sum)
    );

    // Nearly full once the new count reaches len minus the headroom.
    assign full = (WW'(cnt_sum) + WW'(TX_HEADROOM)) >= WW'(len);
endmodule

// File: rtl/irq_coalescer.sv
// Module: interrupt coalescing controller (top).
// Accumulates cause bits and counts pending transmit and receive work. It
// delivers at once on a first receive event, on a one-shot low-threshold
// receive event or on a nearly full transmit ring, and otherwise defers the
// delivery to an armed flush. Events in one cycle are applied in the order
// transmit, receive, flush and merge into one registered pulse.
// Assumes: tx_head and tx_tail are below ring_len; RX_SENTINEL >= 2.
module irq_coalescer
    import irq_coal_pkg::*;
#(
    parameter int IDX_W       = 8,
    parameter int CAUSE_W     = 16,
    parameter int RX_SENTINEL = 100000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_req,
    input  logic [IDX_W-1:0]   tx_head,
    input  logic [IDX_W-1:0]   tx_tail,
    input  logic [IDX_W-1:0]   ring_len,
    input  logic [CAUSE_W-1:0] tx_cause,
    input  logic               rx_evt,
    input  logic [CAUSE_W-1:0] rx_cause,
    input  logic               rx_low,
    input  logic               flush,
    output logic               irq_set,
    output logic [CAUSE_W-1:0] irq_cause,
    output logic               tx_kick
);
    localparam int               CNT_W  = $clog2(RX_SENTINEL + 1);
    localparam logic [CNT_W-1:0] SENT_V = CNT_W'(RX_SENTINEL);

    logic [CNT_W-1:0]   tx_cnt_q, rx_cnt_q, tx_cnt_d, rx_cnt_d;
    logic [CAUSE_W-1:0] acc_q, acc_d, out_d;
    logic               armed_q, armed_d, fire_d, kick_d;
    logic               tx_drop, tx_full;
    logic [CNT_W-1:0]   tx_sum, rx_inc;
    logic [CAUSE_W-1:0] irq_cause_q;
    logic               irq_set_q, kick_q;

    irq_coal_tx_gate #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_tx_gate (
        .head    (tx_head),
        .tail    (tx_tail),
        .len     (ring_len),
        .cnt     (tx_cnt_q),
        .drop    (tx_drop),
        .full    (tx_full),
        .cnt_sum (tx_sum)
    );

    irq_coal_sat_add #(.W(CNT_W), .BW(1)) u_rx_inc (
        .a (rx_cnt_q),
        .b (1'b1),
        .y (rx_inc)
    );

    // Next-state: apply transmit, then receive, then flush, merging all deliveries.
    always_comb begin
        tx_cnt_d = tx_cnt_q;
        rx_cnt_d = rx_cnt_q;
        acc_d    = acc_q;
        armed_d  = armed_q;
        out_d    = '0;
        fire_d   = 1'b0;
        kick_d   = 1'b0;

        if (tx_req && !tx_drop) begin
            acc_d    = acc_d | tx_cause;
            tx_cnt_d = tx_sum;
            if (tx_full) begin
                out_d    = out_d | acc_d;
                acc_d    = '0;
                tx_cnt_d = '0;
                fire_d   = 1'b1;
                if (rx_cnt_d == '0)
                    armed_d = 1'b0;
            end else begin
                armed_d = 1'b1;
            end
        end

        if (rx_evt) begin
            acc_d = acc_d | rx_cause;
            if (rx_cnt_q == '0) begin
                out_d    = out_d | acc_d;
                acc_d    = '0;
                rx_cnt_d = CNT_W'(1);
                fire_d   = 1'b1;
            end else if (rx_low && (rx_cnt_q < SENT_V)) begin
                out_d    = out_d | acc_d;
                acc_d    = '0;
                rx_cnt_d = SENT_V;
                fire_d   = 1'b1;
            end else begin
                rx_cnt_d = rx_inc;
                armed_d  = 1'b1;
            end
        end

        if (flush && armed_d) begin
            armed_d = 1'b0;
            if ((tx_cnt_d != '0) || (rx_cnt_d != '0)) begin
                tx_cnt_d = '0;
                rx_cnt_d = '0;
                out_d    = out_d | acc_d;
                acc_d    = '0;
                fire_d   = 1'b1;
                kick_d   = 1'b1;
            end
        end
    end

    // State and registered outputs, cleared by synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_cnt_q    <= '0;
            rx_cnt_q    <= '0;
            acc_q       <= '0;
            armed_q     <= 1'b0;
            irq_set_q   <= 1'b0;
            irq_cause_q <= '0;
            kick_q      <= 1'b0;
        end else begin
            tx_cnt_q    <= tx_cnt_d;
            rx_cnt_q    <= rx_cnt_d;
            acc_q       <= acc_d;
            armed_q     <= armed_d;
            irq_set_q   <= fire_d;
            irq_cause_q <= out_d;
            kick_q      <= kick_d;
        end
    end

    assign irq_set   = irq_set_q;
    assign irq_cause = irq_cause_q;
    assign tx_kick   = kick_q;

    // R8: a kick only ever travels with an interrupt pulse.
    a_r8_kick_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
        tx_kick |-> irq_set);

    // R5: a receive event on a zero receive count fires in the next cycle.
    a_r5_first_rx_fires: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_evt && rx_cnt_q == '0) |=> irq_set);

    // R9: a lone flush while not armed stays silent.
    a_r9_idle_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !armed_q && !tx_req && !rx_evt) |=> (!irq_set && !tx_kick));

    // R6: the low-threshold bypass does not fire again in one window.
    a_r6_bypass_once: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_evt && rx_low && rx_cnt_q >= SENT_V && !tx_req && !flush) |=> !irq_set);

    // R8: an effective flush empties both counts and kicks.
    a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && armed_q && (tx_cnt_q != '0 || rx_cnt_q != '0) && !tx_req && !rx_evt)
        |=> (tx_cnt_q == '0 && rx_cnt_q == '0 && tx_kick));

    // R11: the receive count never steps down except through a delivery or a flush.
    a_r11_rx_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_evt && rx_cnt_q != '0 && !flush && !(rx_low && rx_cnt_q < SENT_V))
        |=> (rx_cnt_q >= $past(rx_cnt_q)));
endmodule

// File: tb/irq_coalescer_tb.sv
module irq_coalescer_tb;
    localparam int IDX_W = 4;
    localparam int CW    = 4;
    localparam int SENT  = 20;
    localparam int MAXC  = 31;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tx_req = 1'b0, rx_evt = 1'b0, rx_low = 1'b0, flush = 1'b0;
    logic [IDX_W-1:0] tx_head = '0, tx_tail = '0, ring_len = 4'd12;
    logic [CW-1:0] tx_cause = '0, rx_cause = '0;
    logic          irq_set, tx_kick;
    logic [CW-1:0] irq_cause;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    int m_tx = 0, m_rx = 0, m_cause = 0;
    bit m_arm = 1'b0;

    irq_coalescer #(.IDX_W(IDX_W), .CAUSE_W(CW), .RX_SENTINEL(SENT)) u_dut (
        .clk (clk), .rst_n (rst_n), .tx_req (tx_req), .tx_head (tx_head),
        .tx_tail (tx_tail), .ring_len (ring_len), .tx_cause (tx_cause),
        .rx_evt (rx_evt), .rx_cause (rx_cause), .rx_low (rx_low), .flush (flush),
        .irq_set (irq_set), .irq_cause (irq_cause), .tx_kick (tx_kick)
    );

    always #4 clk = ~clk;

    function automatic int sat(input int v);
        return (v > MAXC) ? MAXC : v;
    endfunction

    // Expected behaviour derived from the requirements, one cycle of inputs.
    task automatic model(input bit t, input int h, input int tl, input int L, input int cs,
                         input bit r, input int rc, input bit lo, input bit f,
                         output bit es, output int ec, output bit ek);
        int pend;
        es = 0; ec = 0; ek = 0;
        if (t) begin
            pend = tl - h;
            if (pend < 0) pend += L;
            if (!(m_tx > 4 && m_tx + pend < L - 5)) begin
                m_cause |= cs;
                m_tx = sat(m_tx + pend);
                if (m_tx >= L - 5) begin
                    ec |= m_cause; m_cause = 0; m_tx = 0; es = 1;
                    if (m_rx == 0) m_arm = 0;
                end else m_arm = 1;
            end
        end
        if (r) begin
            m_cause |= rc;
            if (m_rx == 0) begin
                ec |= m_cause; m_cause = 0; m_rx = 1; es = 1;
            end else if (lo && m_rx < SENT) begin
                ec |= m_cause; m_cause = 0; m_rx = SENT; es = 1;
            end else begin
                m_rx = sat(m_rx + 1); m_arm = 1;
            end
        end
        if (f && m_arm) begin
            m_arm = 0;
            if (m_tx != 0 || m_rx != 0) begin
                m_tx = 0; m_rx = 0; ek = 1; ec |= m_cause; m_cause = 0; es = 1;
            end
        end
    endtask

    task automatic check_val(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one cycle of inputs, then compare the registered outputs after the edge.
    task automatic step(input string tag, input bit t, input int h, input int tl, input int L,
                        input int cs, input bit r, input int rc, input bit lo, input bit f);
        bit es, ek;
        int ec;
        @(negedge clk);
        tx_req = t; tx_head = IDX_W'(h); tx_tail = IDX_W'(tl); ring_len = IDX_W'(L);
        tx_cause = CW'(cs); rx_evt = r; rx_cause = CW'(rc); rx_low = lo; flush = f;
        model(t, h, tl, L, cs, r, rc, lo, f, es, ec, ek);
        @(posedge clk);
        #1;
        checks++;
        if (irq_set !== es || tx_kick !== ek || (es && irq_cause !== CW'(ec))) begin
            errors++;
            $display("FAIL %s actual set=%0b kick=%0b cause=%0h expected set=%0b kick=%0b cause=%0h",
                     tag, irq_set, tx_kick, irq_cause, es, ek, ec);
        end
    endtask

    task automatic idle(input string tag);
        step(tag, 0, 0, 0, 12, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check_val("R1 irq_set in reset", int'(irq_set), 0);
        check_val("R1 tx_kick in reset", int'(tx_kick), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R5: the first receive event after reset fires at once.
        step("R5", 0, 0, 0, 12, 0, 1, 4'b0001, 0, 0);
        check_val("R5 cause", int'(irq_cause), 4'b0001);
        idle("R12");
        // R7: the second receive event is deferred.
        step("R7", 0, 0, 0, 12, 0, 1, 4'b0010, 0, 0);
        // R8: the flush delivers the held bits and kicks.
        step("R8", 0, 0, 0, 12, 0, 0, 0, 0, 1);
        check_val("R8 kick", int'(tx_kick), 1);
        step("R9", 0, 0, 0, 12, 0, 0, 0, 0, 1);
        // R4: accepted transmit requests below the threshold defer.
        step("R4", 1, 0, 3, 12, 4'b0100, 0, 0, 0, 0);
        step("R4", 1, 3, 5, 12, 4'b1000, 0, 0, 0, 0);
        // R3: count 5 > 4 and 5+1 < 7, so this request is dropped.
        step("R3", 1, 5, 6, 12, 4'b0001, 0, 0, 0, 0);
        // R2: wrap 10 -> 1 gives 3 pending; count 8 reaches 7 and fires without the dropped bit.
        step("R2", 1, 10, 1, 12, 4'b0010, 0, 0, 0, 0);
        check_val("R3 dropped bit absent", int'(irq_cause), 4'b1110);
        step("R9", 0, 0, 0, 12, 0, 0, 0, 0, 1);
        // R6: a first event, then the bypass, then a second low event that stays deferred.
        step("R5", 0, 0, 0, 12, 0, 1, 4'b0001, 0, 0);
        step("R6", 0, 0, 0, 12, 0, 1, 4'b0010, 1, 0);
        step("R6", 0, 0, 0, 12, 0, 1, 4'b0100, 1, 0);
        // R11: push the receive count into saturation; a wrap would refire.
        for (int i = 0; i < 14; i++)
            step("R11", 0, 0, 0, 12, 0, 1, 4'b1000, 0, 0);
        step("R8", 0, 0, 0, 12, 0, 0, 0, 0, 1);
        check_val("R8 cause", int'(irq_cause), 4'b1100);
        // R10: a deferred transmit and a first receive event in one cycle merge.
        step("R10", 1, 0, 2, 12, 4'b0100, 1, 4'b0001, 0, 0);
        check_val("R10 merged cause", int'(irq_cause), 4'b0101);
        step("R10", 0, 0, 0, 12, 0, 1, 4'b0010, 0, 1);
        idle("R12");

        // R2: sweep ring lengths and head/tail pairs with mixed receive and flush traffic.
        for (int L = 6; L <= 15; L++)
            for (int h = 0; h < L; h++)
                for (int t = 0; t < L; t++)
                    step("R2", 1, h, t, L, (h + t) % 16, ((h * 3 + t) % 5) == 0,
                         (h ^ t) % 16, (t % 4) == 0, (t % 3) == 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule